// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block picks the two ALU operands for the instruction in the execute stage of a five-stage in-order pipeline. The register file has 32 entries. The two source register numbers in the decode/execute register are compared with the destination registers of the two older instructions that have not yet written back:

- the instruction in the execute/memory register, which holds an ALU result;
- the instruction in the memory/writeback register, which holds its final result.

When an older instruction will write a register that the current instruction reads, its value goes straight to the operand. The instruction does not wait for writeback.

Register 31 always reads as zero. A write to register 31 is discarded, so an instruction with destination 31 is never a forwarding source. If both older instructions write the register being read, the newer one (in execute/memory) wins. The block also produces two further values:

- The second ALU operand comes from a last 2:1 mux that chooses between the forwarded value and the sign-extended immediate.
- The forwarded second source is also brought out on its own as store data, so a store gets the correct data while the ALU adds the immediate to the address.

The block is purely combinational.

Top module: `fwd_operand_select`

## Requirements
- R1: Each operand select uses this encoding: 2'b00 passes the register-file value from decode/execute, 2'b01 passes the memory/writeback result, and 2'b10 passes the execute/memory ALU result. The forwarded operand equals the value that its select names.
- R2: When the execute/memory write enable is high, its destination is not 31 and it equals an operand's source register, that operand's select is 2'b10.
- R3: When the memory/writeback write enable is high, its destination is not 31, it equals an operand's source register and R2 does not apply to that operand, the select is 2'b01.
- R4: When both older stages qualify for the same operand, the select is 2'b10 and the execute/memory result is used.
- R5: A destination of 31 in either stage never causes forwarding from that stage, even when the source register is also 31.
- R6: A stage whose write enable is low never forwards, even when its destination matches.
- R7: The first operand compares only against the first source field (rn). The second operand compares only against the second source field (rm). The two selects are decided independently.
- R8: When alu_src is 1, the second ALU operand is the immediate. When alu_src is 0, it is the forwarded second source.
- R9: The store data output is always the forwarded second source, whatever the value of alu_src.
- R10: The select value 2'b11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_ex_rn | input | 5 | First source register number of the execute-stage instruction |
| id_ex_rm | input | 5 | Second source register number of the execute-stage instruction |
| ex_mem_rd | input | 5 | Destination register held in execute/memory |
| ex_mem_wen | input | 1 | Register write enable held in execute/memory |
| mem_wb_rd | input | 5 | Destination register held in memory/writeback |
| mem_wb_wen | input | 1 | Register write enable held in memory/writeback |
| rf_rn_data | input | 64 | Register-file value for the first source |
| rf_rm_data | input | 64 | Register-file value for the second source |
| ex_mem_alu_result | input | 64 | ALU result held in execute/memory |
| mem_wb_result | input | 64 | Result held in memory/writeback |
| imm_ext | input | 64 | Sign-extended immediate |
| alu_src | input | 1 | 1 selects the immediate as the second ALU operand |
| fwd_a_sel | output | 2 | Forwarding select for the first operand |
| fwd_b_sel | output | 2 | Forwarding select for the second operand |
| alu_op_a | output | 64 | First ALU operand |
| alu_op_b | output | 64 | Second ALU operand |
| store_data | output | 64 | Forwarded second source, used as store data |

## Verification
The block holds no state, so any fault in its comparison or priority logic appears on the selects and operands in the same cycle as the input pattern that exposes it. A wrong priority shows only when both older stages match the same source. A missing zero-register guard shows only when a destination is 31. Each of these patterns therefore gets its own directed vector.

The data inputs all carry distinct values. This means a select that routes the wrong source produces an operand value that cannot be mistaken for the expected one.

The second operand is checked with alu_src at both values, and store data is checked at the same time. This exposes any leak of the immediate into the store path.

// File: rtl/fwd_operand_select.sv
module fwd_operand_select #(
  parameter int RW       = 5,
  parameter int DW       = 64,
  parameter int ZERO_REG = 31
) (
  input  logic [RW-1:0] id_ex_rn,
  input  logic [RW-1:0] id_ex_rm,
  input  logic [RW-1:0] ex_mem_rd,
  input  logic          ex_mem_wen,
  input  logic [RW-1:0] mem_wb_rd,
  input  logic          mem_wb_wen,
  input  logic [DW-1:0] rf_rn_data,
  input  logic [DW-1:0] rf_rm_data,
  input  logic [DW-1:0] ex_mem_alu_result,
  input  logic [DW-1:0] mem_wb_result,
  input  logic [DW-1:0] imm_ext,
  input  logic          alu_src,
  output logic [1:0]    fwd_a_sel,
  output logic [1:0]    fwd_b_sel,
  output logic [DW-1:0] alu_op_a,
  output logic [DW-1:0] alu_op_b,
  output logic [DW-1:0] store_data
);
  localparam logic [RW-1:0] ZR      = RW'(ZERO_REG);
  localparam logic [1:0]    SEL_RF  = 2'b00;
  localparam logic [1:0]    SEL_WB  = 2'b01;
  localparam logic [1:0]    SEL_MEM = 2'b10;

  logic mem_live, wb_live;
  logic mem_hit_a, mem_hit_b, wb_hit_a, wb_hit_b;

  assign mem_live  = ex_mem_wen && (ex_mem_rd != ZR);
  assign wb_live   = mem_wb_wen && (mem_wb_rd != ZR);
  assign mem_hit_a = mem_live && (ex_mem_rd == id_ex_rn);
  assign mem_hit_b = mem_live && (ex_mem_rd == id_ex_rm);
  assign wb_hit_a  = wb_live  && (mem_wb_rd == id_ex_rn);
  assign wb_hit_b  = wb_live  && (mem_wb_rd == id_ex_rm);

  assign fwd_a_sel = mem_hit_a ? SEL_MEM : (wb_hit_a ? SEL_WB : SEL_RF);
  assign fwd_b_sel = mem_hit_b ? SEL_MEM : (wb_hit_b ? SEL_WB : SEL_RF);

  always_comb begin
    case (fwd_a_sel)
      SEL_MEM: alu_op_a = ex_mem_alu_result;
      SEL_WB:  alu_op_a = mem_wb_result;
      default: alu_op_a = rf_rn_data;
    endcase
    case (fwd_b_sel)
      SEL_MEM: store_data = ex_mem_alu_result;
      SEL_WB:  store_data = mem_wb_result;
      default: store_data = rf_rm_data;
    endcase
  end

  assign alu_op_b = alu_src ? imm_ext : store_data;

  always_comb begin
    if (!$isunknown({id_ex_rn, id_ex_rm, ex_mem_rd, ex_mem_wen, mem_wb_rd, mem_wb_wen, alu_src})) begin
      AST_SEL_LEGAL: assert (fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11); // R10
      AST_NEWER_WINS_A: assert (!(ex_mem_wen && ex_mem_rd != ZR && ex_mem_rd == id_ex_rn) || fwd_a_sel == SEL_MEM); // R4
      AST_ZERO_DEST: assert (!(ex_mem_rd == ZR && mem_wb_rd == ZR) || (fwd_a_sel == SEL_RF && fwd_b_sel == SEL_RF)); // R5
      AST_NO_WEN: assert (ex_mem_wen || mem_wb_wen || (fwd_a_sel == SEL_RF && fwd_b_sel == SEL_RF)); // R6
      AST_IMM_PATH: assert (!alu_src || fwd_b_sel == SEL_RF || alu_op_b != store_data || imm_ext == store_data); // R8
      AST_WB_ONLY_B: assert (!(fwd_b_sel == SEL_WB) || (mem_wb_wen && mem_wb_rd == id_ex_rm)); // R3
    end
  end
endmodule

// File: tb/fwd_operand_select_test.sv
module fwd_operand_select_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [4:0]  rn, rm, xm_rd, mw_rd;
  logic        xm_wen, mw_wen, alu_src;
  logic [63:0] rf_a, rf_b, xm_val, mw_val, imm;
  logic [1:0]  sel_a, sel_b;
  logic [63:0] op_a, op_b, sdata;
  int vectors = 0, errors = 0;
  bit done = 0;

  fwd_operand_select uut (
    .id_ex_rn(rn), .id_ex_rm(rm), .ex_mem_rd(xm_rd), .ex_mem_wen(xm_wen),
    .mem_wb_rd(mw_rd), .mem_wb_wen(mw_wen), .rf_rn_data(rf_a), .rf_rm_data(rf_b),
    .ex_mem_alu_result(xm_val), .mem_wb_result(mw_val), .imm_ext(imm), .alu_src(alu_src),
    .fwd_a_sel(sel_a), .fwd_b_sel(sel_b), .alu_op_a(op_a), .alu_op_b(op_b), .store_data(sdata)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] a, input logic [4:0] b,
                       input logic [4:0] xr, input logic xw,
                       input logic [4:0] mr, input logic mw, input logic src);
    @(posedge clk);
    rn = a; rm = b; xm_rd = xr; xm_wen = xw; mw_rd = mr; mw_wen = mw; alu_src = src;
    @(negedge clk);
  endtask

  function automatic logic [63:0] val(input logic [1:0] s, input logic [63:0] rf);
    return (s == 2'b10) ? xm_val : (s == 2'b01) ? mw_val : rf;
  endfunction

  task automatic expect_ops(input string req, input logic [1:0] ea, input logic [1:0] eb);
    chk({req, " sel_a"}, {62'd0, sel_a}, {62'd0, ea});
    chk({req, " sel_b"}, {62'd0, sel_b}, {62'd0, eb});
    chk({req, " op_a"}, op_a, val(ea, rf_a));
    chk({req, " store"}, sdata, val(eb, rf_b));
    chk({req, " op_b"}, op_b, alu_src ? imm : val(eb, rf_b));
  endtask

  task automatic t_idle;      drive(5'd1, 5'd2, 5'd1, 1'b0, 5'd2, 1'b0, 1'b0); expect_ops("R6 idle", 2'b00, 2'b00); endtask
  task automatic t_back2back; drive(5'd3, 5'd4, 5'd3, 1'b1, 5'd9, 1'b1, 1'b0); expect_ops("R2 R7 back-to-back", 2'b10, 2'b00); endtask
  task automatic t_twoapart;  drive(5'd5, 5'd6, 5'd8, 1'b1, 5'd6, 1'b1, 1'b0); expect_ops("R3 R7 two-apart", 2'b00, 2'b01); endtask
  task automatic t_both;      drive(5'd7, 5'd7, 5'd7, 1'b1, 5'd7, 1'b1, 1'b0); expect_ops("R4 both stages", 2'b10, 2'b10); endtask
  task automatic t_zero_mem;  drive(5'd31, 5'd31, 5'd31, 1'b1, 5'd12, 1'b1, 1'b0); expect_ops("R5 dest31 in ex/mem", 2'b00, 2'b00); endtask
  task automatic t_zero_wb;   drive(5'd31, 5'd10, 5'd10, 1'b1, 5'd31, 1'b1, 1'b0); expect_ops("R5 dest31 in mem/wb", 2'b00, 2'b10); endtask
  task automatic t_zero_mix;  drive(5'd31, 5'd15, 5'd31, 1'b1, 5'd31, 1'b1, 1'b0); expect_ops("R5 dest31 both", 2'b00, 2'b00); endtask
  task automatic t_mem_blk;   drive(5'd14, 5'd14, 5'd14, 1'b0, 5'd14, 1'b1, 1'b0); expect_ops("R6 R3 ex/mem wen low", 2'b01, 2'b01); endtask
  task automatic t_imm;       drive(5'd2, 5'd20, 5'd20, 1'b1, 5'd2, 1'b1, 1'b1); expect_ops("R8 R9 immediate", 2'b01, 2'b10); endtask
  task automatic t_imm_wb;    drive(5'd0, 5'd21, 5'd3, 1'b1, 5'd21, 1'b1, 1'b1); expect_ops("R9 R1 store via mem/wb", 2'b00, 2'b01); endtask

  initial begin
    rf_a = 64'h1111_0000_0000_00A1; rf_b = 64'h2222_0000_0000_00B2;
    xm_val = 64'h3333_0000_0000_00C3; mw_val = 64'h4444_0000_0000_00D4;
    imm = 64'hFFFF_FFFF_FFFF_FFE8;
    t_idle; t_back2back; t_twoapart; t_both; t_zero_mem;
    t_zero_wb; t_zero_mix; t_mem_blk; t_imm; t_imm_wb;
    chk("R10 no 11 select", {63'd0, (sel_a == 2'b11 || sel_b == 2'b11)}, 64'd0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        vectors++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule